// File: doc/BRIEF.md
# Duty-coded motor command serializer

This block turns a 16-bit motor command word into a train of fixed-length pulse periods on one output pin. Each period carries one bit. A one is sent as a high time of two thirds of the period and a zero as one third. A free-running counter counts from 0 up to a programmable reload value and then wraps to 0, so one period lasts reload + 1 clock cycles. A new high-time threshold is loaded into a double-buffered register only at the wrap, so the duty never changes in the middle of a period.

Software or a control loop offers a word with a one-cycle `start_i` pulse while `ready_o` is high. The word is held until the next counter wrap. The period that begins at that wrap carries the most significant bit, and no period is lost to a late threshold load. After the sixteenth bit the block sends three zero-duty periods, during which the output stays fully low. This gap lets the receiver tell one frame from the next. `ready_o` goes high again once the last gap period has ended. While no frame is active the counter keeps running and the output stays low.

Top module: `pulse_cmd_serializer`

## Requirements
- R1: While reset is asserted and right after it is released, `ready_o` is 1 and `pulse_o` is 0.
- R2: The period counter runs from 0 to `reload_i` and then wraps to 0, so each bit slot spans `reload_i`+1 clock cycles and begins in the cycle after a wrap.
- R3: In a data slot, `pulse_o` is high for the first floor(2P/3) cycles when the bit is 1, and for the first floor(P/3) cycles when the bit is 0 (P = `reload_i`). It is low for the rest of the slot.
- R4: The word is sent most significant bit first: bit 15 goes in the first slot and bit 0 in the sixteenth.
- R5: The first slot of a frame is the one that begins at the first counter wrap after the cycle in which `start_i` is accepted, and it carries bit 15.
- R6: The three slots after the last data bit hold `pulse_o` low for the whole slot.
- R7: `ready_o` drops in the cycle after a start is accepted. It rises in the cycle after the wrap that ends the third gap slot.
- R8: A `start_i` pulse while `ready_o` is 0 is ignored: the frame in flight is not altered and no further frame is queued.
- R9: While `ready_o` is 1, `pulse_o` is 0.
- R10: The active threshold changes only when the counter wraps, so no slot mixes two duty values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; also the counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | CNT_W | Counter reload value P; a period is P+1 cycles; change only while ready is high |
| start_i | input | 1 | One-cycle request to send `word_i` |
| word_i | input | WORD_W | Command word, sampled when a start is accepted |
| ready_o | output | 1 | High when a new word can be accepted |
| pulse_o | output | 1 | Serial pulse output |

## Verification
The serializer is driven with mixed words (0xA5C3, 0x1234, 0xC001), all ones and all zeros. The mixed words expose bit-order and shift errors. The uniform words isolate each of the two duty thresholds. Frames are started back to back and also after long idle stretches, so the start lands at varying counter phases. This separates a correct first-slot load from one that comes a period late. A start pulse in the middle of a frame with a different word shows whether a busy request leaks in. Reload values of 11, 5 and 239 check that both thresholds follow the period rather than being fixed.

// File: rtl/ser_pkg.sv
package ser_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PEND = 2'd1,
        PH_DATA = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

    // High-time threshold for one bit, derived from the reload value.
    function automatic logic [31:0] duty_threshold(input logic [31:0] reload, input logic bit_val);
        logic [32:0] twice;
        twice = {reload, 1'b0};
        if (bit_val)
            return 32'(twice / 33'd3);
        else
            return reload / 32'd3;
    endfunction

endpackage

// File: rtl/ser_period_counter.sv
module ser_period_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt >= reload_i)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = (st_q.cnt >= reload_i);

    // R2: a wrap always restarts the period at zero
    p_wrap_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (cnt_o == '0));

    // R2: the count never stays above the reload for more than one cycle
    p_no_overshoot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_o > reload_i) |=> (cnt_o == '0));

endmodule

// File: rtl/ser_duty_select.sv
module ser_duty_select #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] reload_i,
    input  logic             bit_i,
    input  logic             gap_i,
    output logic [CNT_W-1:0] thr_o
);
    import ser_pkg::*;

    logic [31:0] raw_thr;

    always_comb begin
        raw_thr = duty_threshold(32'(reload_i), bit_i);
        if (gap_i)
            thr_o = '0;
        else
            thr_o = CNT_W'(raw_thr);
    end

endmodule

// File: rtl/ser_frame_ctrl.sv
module ser_frame_ctrl #(
    parameter int WORD_W    = 16,
    parameter int CNT_W     = 16,
    parameter int GAP_SLOTS = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wrap_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  thr_next_i,
    output logic              cur_bit_o,
    output logic              gap_sel_o,
    output logic [CNT_W-1:0]  thr_o,
    output logic              ready_o,
    output logic              in_gap_o
);
    import ser_pkg::*;

    localparam int TOTAL_SLOTS = WORD_W + GAP_SLOTS;
    localparam int SLOT_W      = $clog2(TOTAL_SLOTS);
    localparam logic [SLOT_W-1:0] GAP_MARK = SLOT_W'(GAP_SLOTS);

    typedef struct packed {
        phase_e            phase;
        logic [WORD_W-1:0] shift;
        logic [SLOT_W-1:0] slots;
        logic [CNT_W-1:0]  thr;
    } frm_st_t;

    frm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == PH_IDLE && start_i) begin
            st_d.phase = PH_PEND;
            st_d.shift = word_i;
        end
        if (wrap_i) begin
            unique case (st_q.phase)
                PH_PEND: begin
                    st_d.thr   = thr_next_i;
                    st_d.shift = st_q.shift << 1;
                    st_d.slots = SLOT_W'(TOTAL_SLOTS - 1);
                    st_d.phase = PH_DATA;
                end
                PH_DATA: begin
                    st_d.thr   = thr_next_i;
                    st_d.slots = st_q.slots - SLOT_W'(1);
                    if (st_q.slots > GAP_MARK)
                        st_d.shift = st_q.shift << 1;
                    else
                        st_d.phase = PH_GAP;
                end
                PH_GAP: begin
                    if (st_q.slots == '0) begin
                        st_d.thr   = '0;
                        st_d.phase = PH_IDLE;
                    end else begin
                        st_d.thr   = thr_next_i;
                        st_d.slots = st_q.slots - SLOT_W'(1);
                    end
                end
                default: st_d.thr = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_IDLE;
            st_q.shift <= '0;
            st_q.slots <= '0;
            st_q.thr   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_bit_o = st_q.shift[WORD_W-1];
    assign gap_sel_o = (st_q.phase == PH_GAP) ||
                       (st_q.phase == PH_DATA && st_q.slots <= GAP_MARK);
    assign thr_o     = st_q.thr;
    assign ready_o   = (st_q.phase == PH_IDLE);
    assign in_gap_o  = (st_q.phase == PH_GAP);

    // R10: the active threshold only moves at a period boundary
    p_thr_at_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(thr_o));

    // R6: every gap slot carries a zero threshold
    p_gap_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_gap_o |-> (thr_o == '0));

    // R7: ready only falls after a start request
    p_ready_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ready_o) |-> $past(start_i));

    // R8: while busy, the held word only moves at a wrap
    p_hold_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ready_o && !wrap_i) |=> $stable(st_q.shift));

endmodule

// File: rtl/pulse_cmd_serializer.sv
module pulse_cmd_serializer #(
    parameter int WORD_W    = 16,
    parameter int CNT_W     = 16,
    parameter int GAP_SLOTS = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              ready_o,
    output logic              pulse_o
);

    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic [CNT_W-1:0] thr_next;
    logic [CNT_W-1:0] thr_act;
    logic             cur_bit;
    logic             gap_sel;
    logic             in_gap;

    ser_period_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .reload_i (reload_i),
        .cnt_o    (cnt),
        .wrap_o   (wrap)
    );

    ser_duty_select #(.CNT_W(CNT_W)) u_duty (
        .reload_i (reload_i),
        .bit_i    (cur_bit),
        .gap_i    (gap_sel),
        .thr_o    (thr_next)
    );

    ser_frame_ctrl #(
        .WORD_W    (WORD_W),
        .CNT_W     (CNT_W),
        .GAP_SLOTS (GAP_SLOTS)
    ) u_frame (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wrap_i     (wrap),
        .start_i    (start_i),
        .word_i     (word_i),
        .thr_next_i (thr_next),
        .cur_bit_o  (cur_bit),
        .gap_sel_o  (gap_sel),
        .thr_o      (thr_act),
        .ready_o    (ready_o),
        .in_gap_o   (in_gap)
    );

    // High while the period count is below the active threshold.
    assign pulse_o = (cnt < thr_act);

    // R9: no pulses while idle
    p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> !pulse_o);

    // R6: gap slots are fully low
    p_gap_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_gap |-> !pulse_o);

endmodule

// File: tb/test_pulse_cmd_serializer.sv
module test_pulse_cmd_serializer;

    localparam int WORD_W = 16;
    localparam int CNT_W  = 16;
    localparam int GAP    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  reload = 16'd11;
    logic              start = 1'b0;
    logic [WORD_W-1:0] word = '0;
    logic              ready;
    logic              pulse;

    always #10 clk = ~clk;

    pulse_cmd_serializer #(
        .WORD_W(WORD_W), .CNT_W(CNT_W), .GAP_SLOTS(GAP)
    ) i_pulse_cmd_serializer (
        .clk_i(clk), .rst_ni(rst_n), .reload_i(reload),
        .start_i(start), .word_i(word), .ready_o(ready), .pulse_o(pulse)
    );

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    string phase_tag = "R1";

    // Behavioural reference: counter, pending word, queue of slot thresholds.
    int mcnt = 0;
    int mthr = 0;
    int mslot = 0;
    bit mbusy = 0, mpend = 0, minframe = 0, mwrap = 0;
    logic [WORD_W-1:0] mword = '0;
    int mq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcnt = 0; mthr = 0; mslot = 0;
            mbusy = 0; mpend = 0; minframe = 0;
            mq.delete();
        end else begin
            mwrap = (mcnt >= int'(reload));
            if (mwrap) begin
                if (mpend) begin
                    mq.delete();
                    for (int i = 0; i < WORD_W; i++)
                        mq.push_back(mword[WORD_W-1-i] ? (2 * int'(reload)) / 3 : int'(reload) / 3);
                    for (int i = 0; i < GAP; i++)
                        mq.push_back(0);
                    mpend = 0; minframe = 1; mslot = 0;
                end
                if (mq.size() > 0) begin
                    mthr = mq.pop_front();
                    mslot++;
                end else if (minframe) begin
                    mthr = 0; minframe = 0; mbusy = 0; mslot = 0;
                end
                mcnt = 0;
            end else begin
                mcnt++;
            end
            if (start && !mbusy && !(mwrap && minframe && mq.size() == 0 && mslot == 0 && 0)) begin
                if (!mbusy) begin
                    mbusy = 1; mpend = 1; mword = word;
                end
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        string ctx;
        bit exp_pulse, exp_ready;
        if (!rst_n) begin
            ctx = "R1";
            exp_pulse = 1'b0; exp_ready = 1'b1;
        end else begin
            exp_pulse = (mcnt < mthr);
            exp_ready = !mbusy;
            if (!mbusy)                    ctx = "R9";
            else if (mslot == 0)           ctx = "R5 R9";
            else if (mslot == 1)           ctx = "R5 R4 R3";
            else if (mslot <= WORD_W)      ctx = "R2 R3 R4 R10";
            else                           ctx = "R6 R10";
        end
        vectors++;
        if (pulse !== exp_pulse) begin
            errors++;
            $display("FAIL %s [%s] cycle %0d pulse_o: actual %b expected %b",
                     ctx, phase_tag, cyc, pulse, exp_pulse);
        end
        vectors++;
        if (ready !== exp_ready) begin
            errors++;
            $display("FAIL R7 [%s] cycle %0d ready_o: actual %b expected %b",
                     phase_tag, cyc, ready, exp_ready);
        end
    end

    task automatic send(input logic [WORD_W-1:0] w);
        while (ready !== 1'b1) @(negedge clk);
        start = 1'b1;
        word  = w;
        @(negedge clk);
        start = 1'b0;
        word  = ~w;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (ready !== 1'b1) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        phase_tag = "R1 reset";
        idle(5);
        rst_n = 1'b1;
        phase_tag = "R9 idle";
        idle(30);

        phase_tag = "R3 R4 R5 mixed word";
        send(16'hA5C3);
        wait_done();

        phase_tag = "R3 all ones then R3 all zeros back to back";
        send(16'hFFFF);
        send(16'h0000);
        wait_done();

        phase_tag = "R8 start while busy";
        idle(7);
        send(16'h8001);
        idle(40);
        start = 1'b1; word = 16'h7FFE;
        @(negedge clk);
        start = 1'b0;
        idle(60);
        start = 1'b1; word = 16'h5555;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        idle(20);

        phase_tag = "R2 R3 reload 5";
        reload = 16'd5;
        idle(3);
        send(16'h1234);
        wait_done();

        phase_tag = "R2 R3 reload 239";
        reload = 16'd239;
        idle(13);
        send(16'hC001);
        wait_done();
        idle(300);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule